// File: doc/BRIEF.md
# Predicated Per-Lane Vector Shifter

This execution unit takes a packed vector of `VLEN` bits, splits it into lanes of 8, 16, 32 or 64 bits as chosen by a size field, and shifts each lane of one operand by the amount held in the matching lane of the other operand. The shift kind is arithmetic right, logical right or logical left. A reversed-operand flag, decoded from the same opcode, swaps which register holds the values and which holds the amounts. The whole lane is read as an unsigned shift count. Counts are never reduced modulo the lane width, so counts that are too large saturate: arithmetic right fills the lane with the sign bit, and both logical shifts return zero.

A per-byte predicate mask governs the write. A lane is active when the predicate bit of its lowest byte is set. Inactive lanes return the incoming destination value unchanged, so the caller can write `result_out` straight back into the destination register. The result is registered. A small state register records what happened in the previous cycle, in one of three states. `ST_IDLE` means no request. `ST_DONE` means a legal request was accepted, and it drives `valid_out`. `ST_FAULT` means an illegal opcode was seen, and it drives `illegal_out`. The state register takes the transition **accept** into `ST_DONE` when a legal request arrives, **reject** into `ST_FAULT` when an illegal request arrives, and **drain** back to `ST_IDLE` when no request is present.

Top module: `vshift_pred_unit`

## Requirements
- R1: While `rst` is high, the next clock edge clears `valid_out`, `illegal_out` and `result_out` to zero.
- R2: A legal request with `valid_in` high in one cycle gives `valid_out` high and the result in the next cycle. A cycle with no request gives `valid_out` low in the following cycle.
- R3: `size` selects the lane width: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. Lane k covers bits [k*W +: W].
- R4: Arithmetic right (opcode 000) shifts by min(amount, W-1) and fills with the sign bit. A count of W-1 or more gives all sign bits.
- R5: Logical right (opcode 001) gives zero when amount >= W. Otherwise it shifts right and fills with zeros.
- R6: Logical left (opcode 011) gives zero when amount >= W. Otherwise it shifts left and fills with zeros.
- R7: The whole W-bit lane is the unsigned count. For example, a count of 9 on an 8-bit lane and a count of 0x0101 on a 16-bit lane both count as out of range; neither is reduced modulo W.
- R8: Opcode bit 2 selects the reversed forms (100, 101, 111). In the forward forms `dst_in` holds the values and `src_in` holds the amounts. In the reversed forms the roles swap. Opcode bits [1:0] pick the shift kind: 00 arithmetic right, 01 logical right, 11 logical left.
- R9: Lane k is active when `pred_in[k*W/8]` is 1. Inactive lanes output their `dst_in` bits unchanged. The other predicate bits have no effect.
- R10: Opcodes 010 and 110 are illegal. They give `illegal_out` high and `valid_out` low next cycle, with `result_out` equal to the `dst_in` that came with the request.
- R11: When `valid_in` is low, `result_out` holds its value in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Request present |
| opcode | input | 3 | Shift kind and reversed flag |
| size | input | 2 | Lane width select |
| dst_in | input | VLEN | Prior destination contents |
| src_in | input | VLEN | Second source register |
| pred_in | input | VLEN/8 | Governing predicate, one bit per byte |
| valid_out | output | 1 | Legal result present |
| illegal_out | output | 1 | Previous request had an illegal opcode |
| result_out | output | VLEN | Value to write back to the destination |

## Verification
The shift is tried with random values and two kinds of amount patterns. The first kind keeps every amount inside the lane width. This tests the fill direction and the sign handling. The second kind uses full-lane random counts, which are nearly always out of range. This tests saturation and would catch any reduction of the count modulo W. Hand-picked lanes set counts exactly at W-1, W and above, and use counts that are small in their low byte but large across the whole lane. Reversed opcodes, sparse predicate masks that set only non-lowest bytes, and illegal opcodes each separate operand routing, lane-enable selection and the reject path from the normal result.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

    typedef enum logic [1:0] {
        SH_ASR = 2'b00,
        SH_LSR = 2'b01,
        SH_BAD = 2'b10,
        SH_LSL = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_DONE  = 2'b01,
        ST_FAULT = 2'b10
    } unit_state_e;

    typedef struct packed {
        shift_kind_e kind;
        logic        swap;
        logic        legal;
    } decoded_op_t;

endpackage

// File: rtl/vshift_decode.sv
module vshift_decode
    import vshift_pkg::*;
(
    input  logic [2:0]  opcode,
    output decoded_op_t dec
);

    always_comb begin
        dec.swap = opcode[2];
        unique case (opcode[1:0])
            2'b00: begin dec.kind = SH_ASR; dec.legal = 1'b1; end
            2'b01: begin dec.kind = SH_LSR; dec.legal = 1'b1; end
            2'b11: begin dec.kind = SH_LSL; dec.legal = 1'b1; end
            default: begin dec.kind = SH_BAD; dec.legal = 1'b0; end
        endcase
    end

endmodule

// File: rtl/vshift_elem.sv
module vshift_elem
    import vshift_pkg::*;
#(
    parameter int W = 8
) (
    input  shift_kind_e    kind,
    input  logic [W-1:0]   val,
    input  logic [W-1:0]   amt,
    output logic [W-1:0]   res
);

    localparam int           LW     = $clog2(W);
    localparam logic [W-1:0] LIM_M1 = W[W-1:0] - 1'b1;
    localparam logic [W-1:0] LIM_M2 = W[W-1:0] - 2'd2;

    logic          too_far;
    logic          asr_clamp;
    logic [LW-1:0] sh_raw;
    logic [LW-1:0] sh_asr;

    always_comb begin
        too_far   = (amt > LIM_M1);
        asr_clamp = (amt > LIM_M2);
        sh_raw    = amt[LW-1:0];
        sh_asr    = asr_clamp ? LIM_M1[LW-1:0] : sh_raw;
    end

    always_comb begin
        unique case (kind)
            SH_ASR: res = W'($signed(val) >>> sh_asr);
            SH_LSR: res = too_far ? '0 : (val >> sh_raw);
            SH_LSL: res = too_far ? '0 : (val << sh_raw);
            default: res = val;
        endcase
    end

endmodule

// File: rtl/vshift_lanes.sv
module vshift_lanes
    import vshift_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int W    = 8
) (
    input  shift_kind_e     kind,
    input  logic [VLEN-1:0] val_vec,
    input  logic [VLEN-1:0] amt_vec,
    output logic [VLEN-1:0] res_vec
);

    localparam int NLANE = VLEN / W;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        vshift_elem #(.W(W)) u_elem (
            .kind (kind),
            .val  (val_vec[k*W +: W]),
            .amt  (amt_vec[k*W +: W]),
            .res  (res_vec[k*W +: W])
        );
    end

endmodule

// File: rtl/vshift_merge.sv
module vshift_merge #(
    parameter int VLEN = 256
) (
    input  logic [1:0]            size,
    input  logic [3:0][VLEN-1:0]  by_size,
    input  logic [VLEN/8-1:0]     pred,
    input  logic [VLEN-1:0]       dst,
    output logic [VLEN-1:0]       merged
);

    localparam int NB = VLEN / 8;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic [IW-1:0] lane_mask;
    logic [VLEN-1:0] chosen;

    always_comb begin
        lane_mask = ~((IW'(1) << size) - IW'(1));
        chosen    = by_size[size];
        merged    = dst;
        for (int b = 0; b < NB; b++) begin
            if (pred[IW'(b) & lane_mask]) begin
                merged[8*b +: 8] = chosen[8*b +: 8];
            end
        end
    end

endmodule

// File: rtl/vshift_pred_unit.sv
module vshift_pred_unit
    import vshift_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [2:0]        opcode,
    input  logic [1:0]        size,
    input  logic [VLEN-1:0]   dst_in,
    input  logic [VLEN-1:0]   src_in,
    input  logic [VLEN/8-1:0] pred_in,
    output logic              valid_out,
    output logic              illegal_out,
    output logic [VLEN-1:0]   result_out
);

    decoded_op_t           dec;
    logic [VLEN-1:0]       val_vec;
    logic [VLEN-1:0]       amt_vec;
    logic [3:0][VLEN-1:0]  by_size;
    logic [VLEN-1:0]       merged;
    unit_state_e           state_q;
    unit_state_e           state_d;
    logic [VLEN-1:0]       result_q;

    vshift_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    always_comb begin
        val_vec = dec.swap ? src_in : dst_in;
        amt_vec = dec.swap ? dst_in : src_in;
    end

    for (genvar g = 0; g < 4; g++) begin : g_size
        vshift_lanes #(.VLEN(VLEN), .W(8 << g)) u_lanes (
            .kind    (dec.kind),
            .val_vec (val_vec),
            .amt_vec (amt_vec),
            .res_vec (by_size[g])
        );
    end

    vshift_merge #(.VLEN(VLEN)) u_merge (
        .size    (size),
        .by_size (by_size),
        .pred    (pred_in),
        .dst     (dst_in),
        .merged  (merged)
    );

    // next-state: accept / reject / drain
    always_comb begin
        state_d = ST_IDLE;
        if (valid_in) begin
            state_d = dec.legal ? ST_DONE : ST_FAULT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (valid_in) begin
            result_q <= dec.legal ? merged : dst_in;
        end
    end

    always_comb begin
        valid_out   = 1'b0;
        illegal_out = 1'b0;
        unique case (state_q)
            ST_DONE:  valid_out   = 1'b1;
            ST_FAULT: illegal_out = 1'b1;
            default: ;
        endcase
        result_out = result_q;
    end

    // R1: reset clears outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!valid_out && !illegal_out && result_out == '0));

    // R2: legal request gives valid next cycle
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_in && opcode[1:0] != 2'b10) |=> (valid_out && !illegal_out));

    // R10: illegal opcode flags and keeps destination
    p_illegal_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (valid_in && opcode[1:0] == 2'b10) |=>
            (illegal_out && !valid_out && result_out == $past(dst_in)));

    // R9: all-clear predicate leaves destination untouched
    p_inactive_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_in && pred_in == '0) |=> (result_out == $past(dst_in)));

    // R11: no request holds result and drops valid
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(result_out) && !valid_out && !illegal_out));

endmodule

// File: tb/tb_vshift_pred_unit.sv
module tb_vshift_pred_unit;

    localparam int VL = 256;
    localparam int NB = VL / 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          valid_in;
    logic [2:0]    opcode;
    logic [1:0]    size;
    logic [VL-1:0] dst_in, src_in;
    logic [NB-1:0] pred_in;
    logic          valid_out, illegal_out;
    logic [VL-1:0] result_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vshift_pred_unit #(.VLEN(VL)) dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .opcode(opcode), .size(size),
        .dst_in(dst_in), .src_in(src_in), .pred_in(pred_in),
        .valid_out(valid_out), .illegal_out(illegal_out), .result_out(result_out)
    );

    function automatic logic [VL-1:0] model(input logic [2:0] opc, input logic [1:0] sz,
            input logic [VL-1:0] d, input logic [VL-1:0] s, input logic [NB-1:0] p);
        logic [VL-1:0] res = d;
        logic [VL-1:0] vv = opc[2] ? s : d;
        logic [VL-1:0] aa = opc[2] ? d : s;
        int w = 8 << sz;
        int nl = VL / w;
        if (opc[1:0] == 2'b10) return d;
        for (int ln = 0; ln < nl; ln++) begin
            logic [63:0] v = '0;
            logic [63:0] a = '0;
            logic [63:0] r;
            logic signed [63:0] sv;
            for (int k = 0; k < w; k++) begin
                v[k] = vv[ln*w + k];
                a[k] = aa[ln*w + k];
            end
            sv = v;
            for (int k = w; k < 64; k++) sv[k] = v[w-1];
            case (opc[1:0])
                2'b00: r = sv >>> ((a > 64'(w-1)) ? (w-1) : int'(a));
                2'b01: r = (a >= 64'(w)) ? 64'd0 : (v >> a);
                default: r = (a >= 64'(w)) ? 64'd0 : (v << a);
            endcase
            if (p[ln*(w/8)]) begin
                for (int k = 0; k < w; k++) res[ln*w + k] = r[k];
            end
        end
        return res;
    endfunction

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] x;
        for (int i = 0; i < VL/32; i++) x[32*i +: 32] = $urandom;
        return x;
    endfunction

    function automatic logic [VL-1:0] small_amts(input logic [1:0] sz);
        logic [VL-1:0] x = '0;
        int w = 8 << sz;
        for (int ln = 0; ln < VL/w; ln++) x[ln*w +: 8] = 8'($urandom % w);
        return x;
    endfunction

    task automatic chk_vec(input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] opc, input logic [1:0] sz,
            input logic [VL-1:0] d, input logic [VL-1:0] s, input logic [NB-1:0] p);
        @(negedge clk);
        valid_in = 1'b1; opcode = opc; size = sz; dst_in = d; src_in = s; pred_in = p;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; valid_in = 1'b0; opcode = '0; size = '0;
        dst_in = '0; src_in = '0; pred_in = '0;
        repeat (3) @(negedge clk);
        chk_bit("R1 valid_out", valid_out, 1'b0);
        chk_bit("R1 illegal_out", illegal_out, 1'b0);
        chk_vec("R1 result_out", result_out, '0);
        rst = 1'b0;
    endtask

    task automatic t_forward_sweep();
        logic [2:0] ops [3] = '{3'b000, 3'b001, 3'b011};
        foreach (ops[i]) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [VL-1:0] d = rand_vec();
                    logic [VL-1:0] s = (m == 0) ? small_amts(2'(sz)) : rand_vec();
                    issue(ops[i], 2'(sz), d, s, '1);
                    chk_bit("R2 valid_out", valid_out, 1'b1);
                    chk_vec(ops[i] == 3'b000 ? "R3/R4 asr" :
                            ops[i] == 3'b001 ? "R3/R5 lsr" : "R3/R6 lsl",
                            result_out, model(ops[i], 2'(sz), d, s, '1));
                end
            end
        end
    endtask

    task automatic t_literals();
        logic [VL-1:0] d = '0, s = '0;
        // R4: 8-bit lanes
        d[31:0] = 32'h8080_4080; s[31:0] = 32'h0107_FFC8;
        issue(3'b000, 2'b00, d, s, '1);
        chk_vec("R4 asr sign fill", {224'd0, result_out[31:0]}, {224'd0, 32'hC0FF_00FF});
        // R7: 8-bit lsl count 9 vs 7
        d = '0; s = '0; d[15:0] = 16'h0101; s[15:0] = 16'h0709;
        issue(3'b011, 2'b00, d, s, '1);
        chk_vec("R7 lsl 8b count 9", {240'd0, result_out[15:0]}, {240'd0, 16'h8000});
        // R7/R5: 16-bit lsr count 0x0101 vs 4
        d = '0; s = '0; d[31:0] = 32'hFFFF_FFFF; s[31:0] = 32'h0004_0101;
        issue(3'b001, 2'b01, d, s, '1);
        chk_vec("R7 lsr 16b count 0x0101", {224'd0, result_out[31:0]}, {224'd0, 32'h0FFF_0000});
        // R6: 64-bit lsl by 63 and 64
        d = '0; s = '0; d[63:0] = 64'd1; d[127:64] = 64'd1; s[63:0] = 64'd63; s[127:64] = 64'd64;
        issue(3'b011, 2'b11, d, s, '1);
        chk_vec("R6 lsl 64b edge", {128'd0, result_out[127:0]}, {128'd0, 64'd0, 64'h8000_0000_0000_0000});
    endtask

    task automatic t_reverse();
        logic [VL-1:0] d = '0, s = '0;
        logic [2:0] ops [3] = '{3'b100, 3'b101, 3'b111};
        d[7:0] = 8'd3; s[7:0] = 8'd1;
        issue(3'b111, 2'b00, d, s, '1);
        chk_vec("R8 reversed lsl literal", {248'd0, result_out[7:0]}, {248'd0, 8'd8});
        foreach (ops[i]) begin
            d = small_amts(2'b10); s = rand_vec();
            issue(ops[i], 2'b10, d, s, '1);
            chk_vec("R8 reversed sweep", result_out, model(ops[i], 2'b10, d, s, '1));
        end
    endtask

    task automatic t_predicate();
        logic [VL-1:0] d = rand_vec(), s = small_amts(2'b10);
        logic [NB-1:0] p = $urandom;
        issue(3'b001, 2'b10, d, s, p);
        chk_vec("R9 random predicate", result_out, model(3'b001, 2'b10, d, s, p));
        p = {NB/4{4'b1110}};
        issue(3'b011, 2'b10, d, s, p);
        chk_vec("R9 non-lowest bits ignored", result_out, d);
    endtask

    task automatic t_illegal();
        logic [2:0] ops [2] = '{3'b010, 3'b110};
        foreach (ops[i]) begin
            logic [VL-1:0] d = rand_vec();
            issue(ops[i], 2'b01, d, rand_vec(), '1);
            chk_bit("R10 illegal_out", illegal_out, 1'b1);
            chk_bit("R10 valid_out low", valid_out, 1'b0);
            chk_vec("R10 dst kept", result_out, d);
        end
    endtask

    task automatic t_hold();
        logic [VL-1:0] d = rand_vec(), s = small_amts(2'b00);
        logic [VL-1:0] e = model(3'b000, 2'b00, d, s, '1);
        issue(3'b000, 2'b00, d, s, '1);
        dst_in = rand_vec(); src_in = rand_vec();
        repeat (3) @(negedge clk);
        chk_vec("R11 result held", result_out, e);
        chk_bit("R11/R2 valid_out idle", valid_out, 1'b0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_forward_sweep();
        t_literals();
        t_reverse();
        t_predicate();
        t_illegal();
        t_hold();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule